// File: doc/BRIEF.md
# Ethernet DMA Control and Status Registers

This block is the software-facing register file of a multi-queue Ethernet DMA engine. A host reaches it through a 32-bit port with separate read and write strobes and a word index covering a 4 KB window. It holds the interrupt event and enable registers, two halt-status registers (transmit and receive), and for each of eight transmit and eight receive rings a base address and a current pointer. It drives three interrupt lines and two vectors of one-cycle restart pulses toward the ring walkers.

The ring walkers talk back through an internal side port. They can set event bits, set halt bits, and move one ring's current pointer per cycle. Software restarts a stopped ring by writing 1 to its halt bit, and repositions a ring by writing its base, which also reloads the pointer.

Top module: `etdma_csr`

## Requirements
- R1: The bus index is the byte address divided by four, over 1024 words. An index that names no register reads as 0x00000000, and a write to it changes no register or output.
- R2: Index 0x010 is a write-only control word. It always reads as zero, and the last value written appears on `ctl_value`.
- R3: The event register (index 0x004) clears every bit written as 1 and keeps every bit written as 0.
- R4: A write to the enable register (index 0x005) replaces it. `tx_irq`, `rx_irq` and `err_irq` are each high when the AND of events and enables has a bit set in bits 31:24, 23:16 or 15:0 respectively. They follow any change to either register in the cycle after it.
- R5: In the transmit halt register (index 0x020), bit 31-i belongs to transmit ring i. Writing 1 there clears the bit and pulses `tx_restart[i]` for exactly one cycle, whether or not the bit was set.
- R6: In the receive halt register (index 0x021), bit 23-i belongs to receive ring i. Writing 1 clears the bit, but `rx_restart[i]` pulses only if the stored bit was 0 before the write.
- R7: A write to a ring base register stores the value with bits 2:0 forced to zero. Transmit ring n has its base at index 0x040+2n and its pointer at 0x041+2n. Receive ring n has its base at 0x080+2n and its pointer at 0x081+2n.
- R8: A base write also loads the same aligned value into that ring's pointer. Bus writes to a pointer index are ignored.
- R9: When an internal event set or halt set hits the same bit as a bus write-one-to-clear in the same cycle, the bit ends up set.
- R10: An internal pointer update (`ptr_upd_rx` set for a receive ring, clear for a transmit ring) loads `ptr_upd_val` into the chosen ring's pointer. If a bus base write hits the same ring in that cycle, the base write wins.
- R11: After reset every register reads zero, and all interrupt lines and restart pulses are low.
- R12: `bus_rdata` carries the addressed register in the cycle after `bus_rd` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 10 | Word index (byte address / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_set | input | 32 | Internal event bits to set |
| tx_halt_set | input | 8 | Internal set of transmit halt flags, one per ring |
| rx_halt_set | input | 8 | Internal set of receive halt flags, one per ring |
| ptr_upd_en | input | 1 | Internal pointer update strobe |
| ptr_upd_rx | input | 1 | Update targets a receive ring when high |
| ptr_upd_ring | input | 3 | Ring number for the update |
| ptr_upd_val | input | 32 | New pointer value |
| tx_irq | output | 1 | Transmit interrupt |
| rx_irq | output | 1 | Receive interrupt |
| err_irq | output | 1 | Error interrupt |
| tx_restart | output | 8 | One-cycle transmit ring restart pulses |
| rx_restart | output | 8 | One-cycle receive ring restart pulses |
| ctl_value | output | 32 | Contents of the write-only control word |

## Verification
The hardest cases to reach from the ports are the same-cycle collisions: an internal set against a bus clear on one event bit, and a walker pointer update against a base write on one ring. The stimulus drives both sources in the same clock and then reads the register back. The conditional receive restart also needs a setup step: a halt flag is first raised through the internal set port, then one write hits that ring and a neighbour that is still clear, so that exactly one pulse is expected.

// File: rtl/etdma_csr_pkg.sv
package etdma_csr_pkg;
  // word indices inside the register window
  localparam int unsigned EVT_IDX    = 32'h004;
  localparam int unsigned MSK_IDX    = 32'h005;
  localparam int unsigned CTL_IDX    = 32'h010;
  localparam int unsigned TXHALT_IDX = 32'h020;
  localparam int unsigned RXHALT_IDX = 32'h021;
  localparam int unsigned TXRING_IDX = 32'h040;
  localparam int unsigned RXRING_IDX = 32'h080;
  // halt register bit that belongs to ring 0
  localparam int unsigned TXHALT_TOP = 31;
  localparam int unsigned RXHALT_TOP = 23;
endpackage

// File: rtl/etdma_irq_unit.sv
module etdma_irq_unit #(
  parameter int DW = 32,
  parameter logic [DW-1:0] TX_GRP  = 32'hFF00_0000,
  parameter logic [DW-1:0] RX_GRP  = 32'h00FF_0000,
  parameter logic [DW-1:0] ERR_GRP = 32'h0000_FFFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          evt_wr,
  input  logic          msk_wr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] set_i,
  output logic [DW-1:0] evt_o,
  output logic [DW-1:0] msk_o,
  output logic          tx_irq,
  output logic          rx_irq,
  output logic          err_irq
);
  logic [DW-1:0] evt_d, msk_d, act_d, clr;

  always_comb begin
    clr   = evt_wr ? wdata : '0;
    evt_d = (evt_o & ~clr) | set_i;   // internal set wins
    msk_d = msk_wr ? wdata : msk_o;
    act_d = evt_d & msk_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_o   <= '0;
      msk_o   <= '0;
      tx_irq  <= 1'b0;
      rx_irq  <= 1'b0;
      err_irq <= 1'b0;
    end else begin
      evt_o   <= evt_d;
      msk_o   <= msk_d;
      tx_irq  <= |(act_d & TX_GRP);
      rx_irq  <= |(act_d & RX_GRP);
      err_irq <= |(act_d & ERR_GRP);
    end
  end

  // R3: written ones are gone next cycle unless set internally
  a_r3_w1c_clears: assert property (@(posedge clk) disable iff (rst)
    evt_wr |=> ((evt_o & $past(wdata) & ~$past(set_i)) == '0));
  // R9: internal set survives a same-cycle clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((evt_o & $past(set_i)) == $past(set_i)));
  // R4: each line tracks its group of the registered event and enable words
  a_r4_tx_line: assert property (@(posedge clk) disable iff (rst)
    tx_irq == ((evt_o & msk_o & TX_GRP) != '0));
  a_r4_rx_line: assert property (@(posedge clk) disable iff (rst)
    rx_irq == ((evt_o & msk_o & RX_GRP) != '0));
  a_r4_err_line: assert property (@(posedge clk) disable iff (rst)
    err_irq == ((evt_o & msk_o & ERR_GRP) != '0));
  a_r4_mask_replaced: assert property (@(posedge clk) disable iff (rst)
    msk_wr |=> (msk_o == $past(wdata)));
endmodule

// File: rtl/etdma_halt_unit.sv
module etdma_halt_unit #(
  parameter int DW            = 32,
  parameter int NR            = 8,
  parameter int TOP           = 31,
  parameter bit ONLY_IF_CLEAR = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic [NR-1:0] set_i,
  output logic [DW-1:0] value_o,
  output logic [NR-1:0] restart_o
);
  logic [NR-1:0] halt_q, wbits, clr, restart_d;

  always_comb begin
    for (int i = 0; i < NR; i++) wbits[i] = wdata[TOP-i];
    clr = wr ? wbits : '0;
  end

  generate
    if (ONLY_IF_CLEAR) begin : g_cond
      assign restart_d = clr & ~halt_q;
    end else begin : g_always
      assign restart_d = clr;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_q    <= '0;
      restart_o <= '0;
    end else begin
      halt_q    <= (halt_q & ~clr) | set_i;
      restart_o <= restart_d;
    end
  end

  always_comb begin
    value_o = '0;
    for (int i = 0; i < NR; i++) value_o[TOP-i] = halt_q[i];
  end

  // R5: a restart pulse is always caused by a write in the previous cycle
  a_r5_pulse_from_write: assert property (@(posedge clk) disable iff (rst)
    (restart_o != '0) |-> $past(wr));
  // R5/R6: written ones are cleared unless set internally (R9)
  a_r5_bits_cleared: assert property (@(posedge clk) disable iff (rst)
    wr |=> ((halt_q & $past(wbits) & ~$past(set_i)) == '0));
  a_r9_halt_set_wins: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((halt_q & $past(set_i)) == $past(set_i)));

  generate
    if (ONLY_IF_CLEAR) begin : g_chk_cond
      // R6: no pulse for a ring whose flag was already stored
      a_r6_no_pulse_when_stored: assert property (@(posedge clk) disable iff (rst)
        wr |=> ((restart_o & $past(halt_q)) == '0));
    end else begin : g_chk_always
      // R5: every written one pulses its ring
      a_r5_pulse_each_one: assert property (@(posedge clk) disable iff (rst)
        wr |=> (restart_o == $past(wbits)));
    end
  endgenerate
endmodule

// File: rtl/etdma_ring_regs.sv
module etdma_ring_regs #(
  parameter int DW         = 32,
  parameter int NR         = 8,
  parameter int ALIGN_BITS = 3,
  localparam int RW        = $clog2(NR)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NR-1:0]          base_wr,
  input  logic [DW-1:0]          wdata,
  input  logic                   upd_en,
  input  logic [RW-1:0]          upd_ring,
  input  logic [DW-1:0]          upd_val,
  output logic [NR-1:0][DW-1:0]  base_o,
  output logic [NR-1:0][DW-1:0]  ptr_o
);
  logic [DW-1:0] aligned;
  assign aligned = {wdata[DW-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      base_o <= '0;
      ptr_o  <= '0;
    end else begin
      for (int n = 0; n < NR; n++) begin
        if (base_wr[n]) begin
          base_o[n] <= aligned;
          ptr_o[n]  <= aligned;       // base write wins over walker
        end else if (upd_en && upd_ring == RW'(n)) begin
          ptr_o[n]  <= upd_val;
        end
      end
    end
  end

  generate
    for (genvar n = 0; n < NR; n++) begin : g_chk
      // R7
      a_r7_base_aligned: assert property (@(posedge clk) disable iff (rst)
        base_o[n][ALIGN_BITS-1:0] == '0);
      // R8
      a_r8_ptr_reload: assert property (@(posedge clk) disable iff (rst)
        base_wr[n] |=> (ptr_o[n] == base_o[n]));
      // R10
      a_r10_walker_update: assert property (@(posedge clk) disable iff (rst)
        (upd_en && upd_ring == RW'(n) && !base_wr[n]) |=> (ptr_o[n] == $past(upd_val)));
    end
  endgenerate
endmodule

// File: rtl/etdma_csr.sv
module etdma_csr
  import etdma_csr_pkg::*;
#(
  parameter int DW         = 32,
  parameter int BYTE_SPAN  = 4096,
  parameter int NRING      = 8,
  parameter int ALIGN_BITS = 3,
  parameter logic [DW-1:0] TX_GRP  = 32'hFF00_0000,
  parameter logic [DW-1:0] RX_GRP  = 32'h00FF_0000,
  parameter logic [DW-1:0] ERR_GRP = 32'h0000_FFFF,
  localparam int AW        = $clog2(BYTE_SPAN / 4),
  localparam int RW        = $clog2(NRING)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [DW-1:0]    evt_set,
  input  logic [NRING-1:0] tx_halt_set,
  input  logic [NRING-1:0] rx_halt_set,
  input  logic             ptr_upd_en,
  input  logic             ptr_upd_rx,
  input  logic [RW-1:0]    ptr_upd_ring,
  input  logic [DW-1:0]    ptr_upd_val,
  output logic             tx_irq,
  output logic             rx_irq,
  output logic             err_irq,
  output logic [NRING-1:0] tx_restart,
  output logic [NRING-1:0] rx_restart,
  output logic [DW-1:0]    ctl_value
);
  localparam int BLK_SH = RW + 1;
  localparam logic [AW-1:0] A_EVT = AW'(EVT_IDX);
  localparam logic [AW-1:0] A_MSK = AW'(MSK_IDX);
  localparam logic [AW-1:0] A_CTL = AW'(CTL_IDX);
  localparam logic [AW-1:0] A_TXH = AW'(TXHALT_IDX);
  localparam logic [AW-1:0] A_RXH = AW'(RXHALT_IDX);
  localparam logic [AW-1:0] TXBLK = AW'(TXRING_IDX >> BLK_SH);
  localparam logic [AW-1:0] RXBLK = AW'(RXRING_IDX >> BLK_SH);

  // ---------------- decode ----------------
  logic          hit_tx_blk, hit_rx_blk, is_ptr;
  logic [RW-1:0] ring_sel;
  logic [NRING-1:0] tx_base_wr, rx_base_wr;

  assign hit_tx_blk = (bus_addr >> BLK_SH) == TXBLK;
  assign hit_rx_blk = (bus_addr >> BLK_SH) == RXBLK;
  assign is_ptr     = bus_addr[0];
  assign ring_sel   = bus_addr[RW:1];

  always_comb begin
    for (int n = 0; n < NRING; n++) begin
      tx_base_wr[n] = bus_wr && hit_tx_blk && !is_ptr && ring_sel == RW'(n);
      rx_base_wr[n] = bus_wr && hit_rx_blk && !is_ptr && ring_sel == RW'(n);
    end
  end

  // ---------------- units ----------------
  logic [DW-1:0] evt_q, msk_q, txh_val, rxh_val;
  logic [NRING-1:0][DW-1:0] tx_base, tx_ptr, rx_base, rx_ptr;

  etdma_irq_unit #(.DW(DW), .TX_GRP(TX_GRP), .RX_GRP(RX_GRP), .ERR_GRP(ERR_GRP)) u_irq (
    .clk(clk), .rst(rst),
    .evt_wr(bus_wr && bus_addr == A_EVT),
    .msk_wr(bus_wr && bus_addr == A_MSK),
    .wdata(bus_wdata), .set_i(evt_set),
    .evt_o(evt_q), .msk_o(msk_q),
    .tx_irq(tx_irq), .rx_irq(rx_irq), .err_irq(err_irq)
  );

  etdma_halt_unit #(.DW(DW), .NR(NRING), .TOP(TXHALT_TOP), .ONLY_IF_CLEAR(1'b0)) u_txh (
    .clk(clk), .rst(rst), .wr(bus_wr && bus_addr == A_TXH), .wdata(bus_wdata),
    .set_i(tx_halt_set), .value_o(txh_val), .restart_o(tx_restart)
  );

  etdma_halt_unit #(.DW(DW), .NR(NRING), .TOP(RXHALT_TOP), .ONLY_IF_CLEAR(1'b1)) u_rxh (
    .clk(clk), .rst(rst), .wr(bus_wr && bus_addr == A_RXH), .wdata(bus_wdata),
    .set_i(rx_halt_set), .value_o(rxh_val), .restart_o(rx_restart)
  );

  etdma_ring_regs #(.DW(DW), .NR(NRING), .ALIGN_BITS(ALIGN_BITS)) u_txring (
    .clk(clk), .rst(rst), .base_wr(tx_base_wr), .wdata(bus_wdata),
    .upd_en(ptr_upd_en && !ptr_upd_rx), .upd_ring(ptr_upd_ring), .upd_val(ptr_upd_val),
    .base_o(tx_base), .ptr_o(tx_ptr)
  );

  etdma_ring_regs #(.DW(DW), .NR(NRING), .ALIGN_BITS(ALIGN_BITS)) u_rxring (
    .clk(clk), .rst(rst), .base_wr(rx_base_wr), .wdata(bus_wdata),
    .upd_en(ptr_upd_en && ptr_upd_rx), .upd_ring(ptr_upd_ring), .upd_val(ptr_upd_val),
    .base_o(rx_base), .ptr_o(rx_ptr)
  );

  // ---------------- write-only control word ----------------
  always_ff @(posedge clk) begin
    if (rst)                            ctl_value <= '0;
    else if (bus_wr && bus_addr == A_CTL) ctl_value <= bus_wdata;
  end

  // ---------------- read path ----------------
  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (bus_addr == A_EVT)      rd_mux = evt_q;
    else if (bus_addr == A_MSK) rd_mux = msk_q;
    else if (bus_addr == A_TXH) rd_mux = txh_val;
    else if (bus_addr == A_RXH) rd_mux = rxh_val;
    else if (hit_tx_blk)        rd_mux = is_ptr ? tx_ptr[ring_sel] : tx_base[ring_sel];
    else if (hit_rx_blk)        rd_mux = is_ptr ? rx_ptr[ring_sel] : rx_base[ring_sel];
    // control word is write-only and every other index is empty: zero
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R2: reading the control word yields zero
  a_r2_wo_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_CTL) |=> (bus_rdata == '0));
  // R12: read data holds while no read is issued
  a_r12_rdata_holds: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/etdma_csr_test.sv
module etdma_csr_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 0, bus_rd = 0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [31:0] evt_set = '0;
  logic [7:0]  tx_halt_set = '0, rx_halt_set = '0;
  logic        ptr_upd_en = 0, ptr_upd_rx = 0;
  logic [2:0]  ptr_upd_ring = '0;
  logic [31:0] ptr_upd_val = '0;
  logic        tx_irq, rx_irq, err_irq;
  logic [7:0]  tx_restart, rx_restart;
  logic [31:0] ctl_value;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  etdma_csr uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_set(evt_set),
    .tx_halt_set(tx_halt_set), .rx_halt_set(rx_halt_set), .ptr_upd_en(ptr_upd_en),
    .ptr_upd_rx(ptr_upd_rx), .ptr_upd_ring(ptr_upd_ring), .ptr_upd_val(ptr_upd_val),
    .tx_irq(tx_irq), .rx_irq(rx_irq), .err_irq(err_irq), .tx_restart(tx_restart),
    .rx_restart(rx_restart), .ctl_value(ctl_value)
  );

  // ---------------- scoreboard ----------------
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        fails++;
        $display("FAIL %s: read got %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string t);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", t, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [9:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    bus_rd = 1; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic idle();
    @(posedge clk); @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    for (int c = 0; c < 50000; c++) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R11 reset state
    chk({29'b0, tx_irq, rx_irq, err_irq}, 32'h0, "R11 irq lines after reset");
    chk({16'b0, tx_restart, rx_restart}, 32'h0, "R11 restart pulses after reset");
    rd(10'h004, 32'h0, "R11 event reg reset");
    rd(10'h005, 32'h0, "R11 mask reg reset");
    rd(10'h041, 32'h0, "R11 tx ptr0 reset");

    // R1 undefined index
    wr(10'h3FF, 32'hFFFF_FFFF);
    rd(10'h3FF, 32'h0, "R1 undefined reads zero");
    rd(10'h006, 32'h0, "R1 empty index reads zero");
    chk({29'b0, tx_irq, rx_irq, err_irq}, 32'h0, "R1 undefined write no irq");

    // R2 write-only control word
    wr(10'h010, 32'hA5A5_0F0F);
    rd(10'h010, 32'h0, "R2 write-only reads zero");
    chk(ctl_value, 32'hA5A5_0F0F, "R2 control value output");

    // R4 masked events: all events, no enables -> no irq
    evt_set = 32'hFFFF_FFFF; idle(); evt_set = '0;
    chk({29'b0, tx_irq, rx_irq, err_irq}, 32'h0, "R4 no enable no irq");
    wr(10'h005, 32'h0100_0000);
    chk({29'b0, tx_irq, rx_irq, err_irq}, 32'h4, "R4 tx group only");
    rd(10'h004, 32'hFFFF_FFFF, "R4 events latched");

    // R3 write-one-to-clear
    wr(10'h004, 32'h0F0F_0000);
    rd(10'h004, 32'hF0F0_FFFF, "R3 w1c result");
    chk({29'b0, tx_irq, rx_irq, err_irq}, 32'h0, "R3 cleared bit drops tx irq");
    wr(10'h005, 32'h0010_0000);
    chk({29'b0, tx_irq, rx_irq, err_irq}, 32'h2, "R4 mask replaced, rx group");
    wr(10'h005, 32'h0000_8000);
    chk({29'b0, tx_irq, rx_irq, err_irq}, 32'h1, "R4 err group");

    // R9 set wins over clear in the same cycle
    evt_set = 32'h0000_0001;
    wr(10'h004, 32'h0000_0003);
    evt_set = '0;
    rd(10'h004, 32'hF0F0_FFFD, "R9 internal set beats w1c");

    // R5 transmit halt
    tx_halt_set = 8'b0000_0100; idle(); tx_halt_set = '0;
    rd(10'h020, 32'h2000_0000, "R5 tx halt bit 31-i");
    wr(10'h020, 32'h2000_0001);
    chk({24'b0, tx_restart}, 32'h04, "R5 tx restart ring2");
    @(negedge clk);
    chk({24'b0, tx_restart}, 32'h00, "R5 tx restart one cycle");
    rd(10'h020, 32'h0, "R5 tx halt cleared");
    wr(10'h020, 32'h8000_0000);
    chk({24'b0, tx_restart}, 32'h01, "R5 tx restart without stored flag");

    // R6 receive halt: stored ring1 no pulse, clear ring2 pulses
    rx_halt_set = 8'b0000_0010; idle(); rx_halt_set = '0;
    rd(10'h021, 32'h0040_0000, "R6 rx halt bit 23-i");
    wr(10'h021, 32'h0060_0000);
    chk({24'b0, rx_restart}, 32'h04, "R6 rx restart only for clear flag");
    @(negedge clk);
    chk({24'b0, rx_restart}, 32'h00, "R6 rx restart one cycle");
    rd(10'h021, 32'h0, "R6 rx halt cleared");

    // R7 / R8 base write aligns and reloads pointer
    wr(10'h046, 32'h1234_5677);
    rd(10'h046, 32'h1234_5670, "R7 tx base3 aligned");
    rd(10'h047, 32'h1234_5670, "R8 tx ptr3 reloaded");
    wr(10'h047, 32'hDEAD_BEEF);
    rd(10'h047, 32'h1234_5670, "R8 ptr ignores bus write");

    // R10 walker update, then conflict with a base write
    ptr_upd_en = 1; ptr_upd_rx = 1; ptr_upd_ring = 3'd5; ptr_upd_val = 32'h0000_ABC4;
    idle();
    ptr_upd_en = 0;
    rd(10'h08B, 32'h0000_ABC4, "R10 walker updates rx ptr5");
    rd(10'h047, 32'h1234_5670, "R10 tx ptr3 untouched by rx update");
    ptr_upd_en = 1; ptr_upd_val = 32'h1111_1110;
    wr(10'h08A, 32'h2222_2223);
    ptr_upd_en = 0;
    rd(10'h08B, 32'h2222_2220, "R10 base write wins over walker");
    rd(10'h08A, 32'h2222_2220, "R7 rx base5 aligned");

    // R12 read data arrives exactly one cycle after the strobe
    exp_q.push_back(32'h0000_8000); tag_q.push_back("R12 read latency");
    bus_rd = 1; bus_addr = 10'h005;
    @(posedge clk); @(negedge clk);
    bus_rd = 0;

    repeat (3) @(negedge clk);
    chk(exp_q.size(), 32'd0, "R12 all reads answered");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule